// File: doc/BRIEF.md
# IDE Scatter-Gather Bus-Master DMA Engine

This block moves sector data for two IDE channels between a byte-wide drive stream and system memory. Each channel follows a table of 8-byte entries held in memory. An entry names one buffer, gives its byte count, and can mark itself as the final entry. Software writes the table's start address into a channel's pointer register. It then sets the start bit in the command register, together with a direction bit. From there the engine fetches entries, fills or drains each buffer in turn, and stops on its own when the buffer of the final entry is exhausted.

Both channels share one 16-byte I/O window and one byte-wide memory port. The memory port accepts a request in the same cycle it is made. Read data returns one cycle later. When both channels request in the same cycle, the primary channel wins. In the drive-to-memory direction a byte is taken from the drive stream only in a cycle where the engine also writes it to memory. In the memory-to-drive direction each byte is read from memory and then held on the drive output until the drive accepts it.

Top module: `ide_sg_dma`

## Requirements
- R1: I/O address bit 3 selects the channel (0 primary, 1 secondary). The low three bits select the register: 0 is command (bit 0 start/active, bit 3 direction, 1 = drive to memory), 2 is status (bit 0 active, bit 2 done), and 4 to 7 are the table pointer bytes, least significant first. Pointer bits 1:0 always read as zero. Writes to one channel leave the other channel unchanged.
- R2: Writing command bit 0 = 1 to an idle channel starts it, and the first entry is fetched from the pointer. An entry is little-endian. Bytes 0 to 3 hold the buffer address. Bytes 4 and 5 hold the count, with bit 0 forced to zero. Bit 7 of byte 7 is the final-entry flag.
- R3: A count field of zero transfers 65536 bytes.
- R4: After each entry is loaded, the pointer has advanced by 8.
- R5: While status bit 0 is clear, no drive byte is accepted (drive ready low) and no memory access is made.
- R6: In the drive-to-memory direction, bytes are written to consecutive addresses of each buffer. When a buffer is exhausted and it is not the final one, the next entry is fetched and filling continues in that entry's buffer.
- R7: When the buffer of the final entry is exhausted, status bit 0 clears, status bit 2 sets, and `done` pulses for one cycle. No further byte is accepted or written. Writing 1 to status bit 2 clears it.
- R8: In the memory-to-drive direction (command bit 3 = 0), the buffer bytes are presented on the drive output in table order. Each byte is held until the drive accepts it.
- R9: Writing command bit 0 = 0 to an active channel stops it at once: status bit 0 clears, no further byte is accepted, and `done` does not pulse.
- R10: The two channels can run at the same time on the shared memory port. The primary channel has priority, and both transfers complete intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 4 | I/O register address (bit 3 channel, bits 2:0 register) |
| io_we | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational from io_addr |
| mem_req | output | 1 | Memory access request, accepted in the same cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid the cycle after a read request |
| dr_valid | input | 2 | Drive-to-engine byte valid, one bit per channel |
| dr_data | input | 16 | Drive-to-engine bytes, channel n in bits 8n+7:8n |
| dr_ready | output | 2 | Engine accepts the drive byte this cycle |
| dt_valid | output | 2 | Engine-to-drive byte valid |
| dt_data | output | 16 | Engine-to-drive bytes, channel n in bits 8n+7:8n |
| dt_ready | input | 2 | Drive accepts the engine byte this cycle |
| done | output | 2 | One-cycle pulse when a channel finishes its table |

## Verification
Register reads are combinational, so the bench samples them in the same cycle it sets the address. Fetching one entry takes 16 cycles, two for each of its eight bytes. In the drive-to-memory direction, each accepted byte shows up as a memory write in the same cycle. In the memory-to-drive direction, a byte reaches the drive output two cycles after its read request. The `done` pulse and the status change appear in the cycle after the last byte moves. The bench's scoreboard therefore compares memory writes and drive-output bytes in the cycle where each handshake happens. It reads status and the `done` count only after the negative edge that follows the final byte, and it holds the drive stream valid for several cycles afterwards to confirm that nothing more is accepted.

// File: rtl/ide_dma_pkg.sv
package ide_dma_pkg;
    localparam int ADDR_W      = 32;
    localparam int CNT_FIELD_W = 16;
    localparam int CNT_W       = CNT_FIELD_W + 1;
    localparam int DESC_BYTES  = 8;
    localparam int DESC_IDX_W  = $clog2(DESC_BYTES);
    localparam int NUM_CH      = 2;

    localparam logic [2:0] OFF_CMD  = 3'd0;
    localparam logic [2:0] OFF_STAT = 3'd2;

    localparam int CMD_START = 0;
    localparam int CMD_DIR   = 3;
    localparam int STAT_ACT  = 0;
    localparam int STAT_DONE = 2;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_FREQ  = 3'd1,
        S_FWAIT = 3'd2,
        S_XFER  = 3'd3,
        S_RWAIT = 3'd4,
        S_SEND  = 3'd5
    } ch_state_e;
endpackage

// File: rtl/ide_dma_arb.sv
module ide_dma_arb
    import ide_dma_pkg::*;
#(
    parameter int N = NUM_CH
) (
    input  logic [N-1:0]             req_i,
    input  logic [N-1:0]             we_i,
    input  logic [N-1:0][ADDR_W-1:0] addr_i,
    input  logic [N-1:0][7:0]        wdata_i,
    output logic [N-1:0]             gnt_o,
    output logic                     mem_req_o,
    output logic                     mem_we_o,
    output logic [ADDR_W-1:0]        mem_addr_o,
    output logic [7:0]               mem_wdata_o
);
    always_comb begin
        gnt_o       = '0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                gnt_o       = '0;
                gnt_o[i]    = 1'b1;
                mem_req_o   = 1'b1;
                mem_we_o    = we_i[i];
                mem_addr_o  = addr_i[i];
                mem_wdata_o = wdata_i[i];
            end
        end
    end

    always_comb begin
        assert_onehot_R10: assert ($onehot0(gnt_o));
        assert_gnt_req_R10: assert ((gnt_o & ~req_i) == '0);
        assert_primary_R10: assert (!req_i[0] || gnt_o[0]);
    end
endmodule

// File: rtl/ide_dma_chan.sv
module ide_dma_chan
    import ide_dma_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              io_we_i,
    input  logic [2:0]        io_off_i,
    input  logic [7:0]        io_wdata_i,
    output logic [7:0]        io_rdata_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [7:0]        mem_wdata_o,
    input  logic              mem_gnt_i,
    input  logic [7:0]        mem_rdata_i,
    input  logic              dr_valid_i,
    input  logic [7:0]        dr_data_i,
    output logic              dr_ready_o,
    output logic              dt_valid_o,
    output logic [7:0]        dt_data_o,
    input  logic              dt_ready_i,
    output logic              done_o
);
    typedef struct packed {
        ch_state_e             state;
        logic                  active;
        logic                  done_st;
        logic                  done_p;
        logic                  dir;
        logic [ADDR_W-1:0]     ptr;
        logic [ADDR_W-1:0]     baddr;
        logic [CNT_W-1:0]      cnt;
        logic                  eot;
        logic                  last;
        logic [DESC_IDX_W-1:0] idx;
        logic [7:0]            hold;
    } ch_t;

    ch_t  q, d;
    logic buf_end;

    always_comb begin
        d           = q;
        d.done_p    = 1'b0;
        buf_end     = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = q.baddr;
        mem_wdata_o = dr_data_i;
        dr_ready_o  = 1'b0;

        case (q.state)
            S_FREQ: begin
                mem_req_o  = 1'b1;
                mem_addr_o = q.ptr + ADDR_W'(q.idx);
                if (mem_gnt_i) d.state = S_FWAIT;
            end
            S_FWAIT: begin
                d.idx   = q.idx + 1'b1;
                d.state = S_FREQ;
                if (!q.idx[2]) begin
                    d.baddr[{q.idx[1:0], 3'b000} +: 8] = mem_rdata_i;
                end else begin
                    case (q.idx[1:0])
                        2'd0: begin
                            d.cnt      = '0;
                            d.cnt[7:0] = {mem_rdata_i[7:1], 1'b0};
                        end
                        2'd1: d.cnt[15:8] = mem_rdata_i;
                        2'd2: ;
                        default: begin
                            d.eot   = mem_rdata_i[7];
                            d.cnt   = (q.cnt[CNT_FIELD_W-1:0] == '0) ?
                                      {1'b1, {CNT_FIELD_W{1'b0}}} : q.cnt;
                            d.ptr   = q.ptr + ADDR_W'(DESC_BYTES);
                            d.state = S_XFER;
                        end
                    endcase
                end
            end
            S_XFER: begin
                if (q.dir) begin
                    mem_req_o  = dr_valid_i;
                    mem_we_o   = 1'b1;
                    dr_ready_o = mem_gnt_i;
                    if (dr_valid_i && mem_gnt_i) begin
                        d.baddr = q.baddr + 1'b1;
                        d.cnt   = q.cnt - 1'b1;
                        buf_end = (q.cnt == CNT_W'(1));
                    end
                end else begin
                    mem_req_o = 1'b1;
                    if (mem_gnt_i) begin
                        d.baddr = q.baddr + 1'b1;
                        d.cnt   = q.cnt - 1'b1;
                        d.last  = (q.cnt == CNT_W'(1));
                        d.state = S_RWAIT;
                    end
                end
            end
            S_RWAIT: begin
                d.hold  = mem_rdata_i;
                d.state = S_SEND;
            end
            S_SEND: begin
                if (dt_ready_i) begin
                    if (q.last) buf_end = 1'b1;
                    else        d.state = S_XFER;
                end
            end
            default: ;
        endcase

        if (buf_end) begin
            if (q.eot) begin
                d.active  = 1'b0;
                d.done_st = 1'b1;
                d.done_p  = 1'b1;
                d.state   = S_IDLE;
            end else begin
                d.idx   = '0;
                d.state = S_FREQ;
            end
        end

        if (io_we_i) begin
            if (io_off_i == OFF_CMD) begin
                d.dir = io_wdata_i[CMD_DIR];
                if (io_wdata_i[CMD_START] && !q.active) begin
                    d.active = 1'b1;
                    d.idx    = '0;
                    d.state  = S_FREQ;
                end else if (!io_wdata_i[CMD_START] && q.active) begin
                    d.active = 1'b0;
                    d.state  = S_IDLE;
                end
            end else if (io_off_i == OFF_STAT) begin
                if (io_wdata_i[STAT_DONE]) d.done_st = 1'b0;
            end else if (io_off_i[2]) begin
                d.ptr[{io_off_i[1:0], 3'b000} +: 8] = io_wdata_i;
                d.ptr[1:0] = 2'b00;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_comb begin
        io_rdata_o = '0;
        if (io_off_i == OFF_CMD) begin
            io_rdata_o[CMD_START] = q.active;
            io_rdata_o[CMD_DIR]   = q.dir;
        end else if (io_off_i == OFF_STAT) begin
            io_rdata_o[STAT_ACT]  = q.active;
            io_rdata_o[STAT_DONE] = q.done_st;
        end else if (io_off_i[2]) begin
            io_rdata_o = q.ptr[{io_off_i[1:0], 3'b000} +: 8];
        end
    end

    assign dt_valid_o = (q.state == S_SEND);
    assign dt_data_o  = q.hold;
    assign done_o     = q.done_p;

    assert_ptr_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == S_FWAIT && q.idx == '1 && !io_we_i) |=> (q.ptr == $past(q.ptr) + ADDR_W'(DESC_BYTES)));
    assert_even_count_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == S_FWAIT && q.idx == '1 && !io_we_i) |=> (q.cnt[0] == 1'b0 && q.cnt != '0));
    assert_refuse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !q.active |-> (!dr_ready_o && !mem_req_o && !dt_valid_o));
    assert_end_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (buf_end && q.eot && !io_we_i) |=> (!q.active && done_o && q.done_st));
    assert_stop_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (io_we_i && io_off_i == OFF_CMD && !io_wdata_i[CMD_START]) |=> (!q.active && !done_o));
endmodule

// File: rtl/ide_sg_dma.sv
module ide_sg_dma
    import ide_dma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        io_addr,
    input  logic              io_we,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic [1:0]        dr_valid,
    input  logic [15:0]       dr_data,
    output logic [1:0]        dr_ready,
    output logic [1:0]        dt_valid,
    output logic [15:0]       dt_data,
    input  logic [1:0]        dt_ready,
    output logic [1:0]        done
);
    logic [NUM_CH-1:0]             ch_req, ch_we, ch_gnt;
    logic [NUM_CH-1:0][ADDR_W-1:0] ch_addr;
    logic [NUM_CH-1:0][7:0]        ch_wdata, ch_rd;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ide_dma_chan u_chan (
            .clk_i       (clk),
            .rst_ni      (rst_n),
            .io_we_i     (io_we && (io_addr[3] == g[0])),
            .io_off_i    (io_addr[2:0]),
            .io_wdata_i  (io_wdata),
            .io_rdata_o  (ch_rd[g]),
            .mem_req_o   (ch_req[g]),
            .mem_we_o    (ch_we[g]),
            .mem_addr_o  (ch_addr[g]),
            .mem_wdata_o (ch_wdata[g]),
            .mem_gnt_i   (ch_gnt[g]),
            .mem_rdata_i (mem_rdata),
            .dr_valid_i  (dr_valid[g]),
            .dr_data_i   (dr_data[8*g +: 8]),
            .dr_ready_o  (dr_ready[g]),
            .dt_valid_o  (dt_valid[g]),
            .dt_data_o   (dt_data[8*g +: 8]),
            .dt_ready_i  (dt_ready[g]),
            .done_o      (done[g])
        );
    end

    ide_dma_arb #(.N(NUM_CH)) u_arb (
        .req_i       (ch_req),
        .we_i        (ch_we),
        .addr_i      (ch_addr),
        .wdata_i     (ch_wdata),
        .gnt_o       (ch_gnt),
        .mem_req_o   (mem_req),
        .mem_we_o    (mem_we),
        .mem_addr_o  (mem_addr),
        .mem_wdata_o (mem_wdata)
    );

    assign io_rdata = ch_rd[io_addr[3]];
endmodule

// File: tb/tb_ide_sg_dma.sv
`timescale 1ns/1ps
module tb_ide_sg_dma;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  io_addr = '0;
    logic        io_we = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;
    logic [1:0]  dr_valid = '0;
    logic [15:0] dr_data = '0;
    logic [1:0]  dr_ready, dt_valid, done;
    logic [15:0] dt_data;
    logic [1:0]  dt_ready = 2'b11;
    logic        stall_en = 1'b0;

    always #4 clk = ~clk;

    ide_sg_dma dut (.*);

    logic [7:0] mem [logic [31:0]];
    always @(posedge clk) begin
        if (mem_req && mem_we) mem[mem_addr] = mem_wdata;
        if (mem_req && !mem_we) mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 8'h00;
    end

    always @(negedge clk) dt_ready <= stall_en ? ~dt_ready : 2'b11;

    int checks = 0, errors = 0;
    int dcnt0 = 0, dcnt1 = 0;
    bit finished = 0;

    typedef struct { logic [31:0] a; logic [7:0] d; } wexp_t;
    wexp_t      wq[$];
    logic [7:0] tq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int s, input int i);
        return 8'((i * 5 + s * 37 + (i >> 7)) & 255);
    endfunction

    // monitor: scoreboard side
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (mem_req && mem_we) begin
                if (wq.size() == 0) begin
                    chk(0, "R7", "memory write past last buffer", mem_addr, 0);
                end else begin
                    wexp_t e;
                    e = wq.pop_front();
                    chk(mem_addr == e.a, "R6", "write address", mem_addr, e.a);
                    chk(mem_wdata == e.d, "R6", "write data", mem_wdata, e.d);
                end
            end
            if (dt_valid[1] && dt_ready[1]) begin
                if (tq.size() == 0) chk(0, "R8", "unexpected drive byte", dt_data[15:8], 0);
                else begin
                    logic [7:0] x;
                    x = tq.pop_front();
                    chk(dt_data[15:8] == x, "R8", "drive output byte", dt_data[15:8], x);
                end
            end
            if (done[0]) dcnt0++;
            if (done[1]) dcnt1++;
        end
    end

    task automatic io_write(input logic [3:0] a, input logic [7:0] v);
        io_addr = a; io_wdata = v; io_we = 1'b1;
        @(negedge clk);
        io_we = 1'b0;
    endtask

    task automatic io_read(input logic [3:0] a, output logic [7:0] v);
        io_addr = a; io_we = 1'b0;
        #1 v = io_rdata;
    endtask

    task automatic set_ptr(input int ch, input logic [31:0] v);
        for (int i = 0; i < 4; i++) io_write(4'(ch * 8 + 4 + i), v[8*i +: 8]);
    endtask

    task automatic put_desc(input logic [31:0] at, input logic [31:0] a,
                            input logic [15:0] c, input bit last);
        for (int i = 0; i < 4; i++) mem[at + 32'(i)] = a[8*i +: 8];
        mem[at + 4] = c[7:0];
        mem[at + 5] = c[15:8];
        mem[at + 6] = 8'h00;
        mem[at + 7] = {last, 7'h00};
    endtask

    task automatic expect_buf(input logic [31:0] a, input int len, input int s, input int start);
        for (int i = 0; i < len; i++) begin
            wexp_t e;
            e.a = a + 32'(i);
            e.d = pat(s, start + i);
            wq.push_back(e);
        end
    endtask

    // driver: entered at a negative edge
    task automatic push_bytes(input int ch, input int n, input int s, input int start);
        for (int i = 0; i < n; i++) begin
            dr_valid[ch] = 1'b1;
            dr_data[ch*8 +: 8] = pat(s, start + i);
            #1;
            while (!dr_ready[ch]) begin @(negedge clk); #1; end
            @(negedge clk);
        end
        dr_valid[ch] = 1'b0;
    endtask

    task automatic refuse_check(input int ch, input int cyc, input string req);
        dr_valid[ch] = 1'b1;
        for (int i = 0; i < cyc; i++) begin
            #1 chk(dr_ready[ch] == 1'b0, req, "drive byte refused", dr_ready[ch], 0);
            @(negedge clk);
        end
        dr_valid[ch] = 1'b0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        errors++;
        $display("FAIL watchdog: run did not finish");
        summary();
    end

    initial begin
        logic [7:0] v;
        int d0, d1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        io_read(4'h2, v); chk(v == 8'h00, "R5", "reset status ch0", v, 0);
        io_read(4'hA, v); chk(v == 8'h00, "R5", "reset status ch1", v, 0);
        chk(mem_req == 1'b0 && done == 2'b00 && dr_ready == 2'b00, "R5", "reset outputs idle",
            {mem_req, done, dr_ready}, 0);

        // R1 register map and channel separation
        set_ptr(0, 32'h0000_1003);
        set_ptr(1, 32'hABCD_1237);
        io_read(4'h4, v); chk(v == 8'h00, "R1", "ch0 ptr byte0 low bits zero", v, 8'h00);
        io_read(4'h5, v); chk(v == 8'h10, "R1", "ch0 ptr byte1", v, 8'h10);
        io_read(4'hC, v); chk(v == 8'h34, "R1", "ch1 ptr byte0 low bits zero", v, 8'h34);
        io_read(4'hF, v); chk(v == 8'hAB, "R1", "ch1 ptr byte3", v, 8'hAB);
        @(negedge clk);

        // R5 refuse while inactive
        refuse_check(0, 5, "R5");

        // R2 R6 R7 R4: three-entry table, 1536 bytes
        put_desc(32'h1000, 32'h2000, 16'd512, 0);
        put_desc(32'h1008, 32'h3001, 16'h0201, 0);
        put_desc(32'h1010, 32'h4000, 16'd512, 1);
        expect_buf(32'h2000, 512, 0, 0);
        expect_buf(32'h3001, 512, 0, 512);
        expect_buf(32'h4000, 512, 0, 1024);
        set_ptr(0, 32'h1000);
        d0 = dcnt0;
        io_write(4'h0, 8'h09);
        push_bytes(0, 1536, 0, 0);
        @(negedge clk);
        io_read(4'h2, v); chk(v == 8'h04, "R7", "status after final buffer", v, 8'h04);
        chk(dcnt0 == d0 + 1, "R7", "single done pulse", dcnt0 - d0, 1);
        chk(wq.size() == 0, "R6", "all writes seen", wq.size(), 0);
        io_read(4'h4, v); chk(v == 8'h18, "R4", "ptr advanced 3x8", v, 8'h18);
        chk(!mem.exists(32'h3201), "R2", "count bit0 forced even", 1, 0);
        chk(!mem.exists(32'h4200), "R7", "nothing past last buffer", 1, 0);
        @(negedge clk);
        refuse_check(0, 4, "R7");
        io_write(4'h2, 8'h04);
        io_read(4'h2, v); chk(v == 8'h00, "R7", "done bit cleared by write one", v, 0);
        @(negedge clk);

        // R8 R10: ch1 memory to drive alongside ch0 drive to memory
        put_desc(32'h5000, 32'h2000, 16'd10, 0);
        put_desc(32'h5008, 32'h3001, 16'd8, 1);
        for (int i = 0; i < 10; i++) tq.push_back(pat(0, i));
        for (int i = 0; i < 8; i++) tq.push_back(pat(0, 512 + i));
        put_desc(32'h6000, 32'h7000, 16'd100, 1);
        expect_buf(32'h7000, 100, 1, 0);
        set_ptr(1, 32'h5000);
        set_ptr(0, 32'h6000);
        stall_en = 1'b1;
        d0 = dcnt0; d1 = dcnt1;
        io_write(4'h8, 8'h01);
        io_write(4'h0, 8'h09);
        push_bytes(0, 100, 1, 0);
        while (dcnt1 == d1) @(negedge clk);
        @(negedge clk);
        stall_en = 1'b0;
        chk(tq.size() == 0, "R8", "all drive bytes delivered", tq.size(), 0);
        chk(wq.size() == 0, "R10", "ch0 writes complete", wq.size(), 0);
        chk(dcnt0 == d0 + 1 && dcnt1 == d1 + 1, "R10", "both channels done",
            {dcnt0 - d0, dcnt1 - d1}, 64'h0000000100000001);
        io_read(4'hA, v); chk(v == 8'h04, "R10", "ch1 status", v, 8'h04);
        io_read(4'hC, v); chk(v == 8'h10, "R4", "ch1 ptr advanced 2x8", v, 8'h10);
        io_write(4'h2, 8'h04);
        io_write(4'hA, 8'h04);

        // R9 stop mid-buffer
        put_desc(32'h6040, 32'h7100, 16'd64, 1);
        expect_buf(32'h7100, 10, 2, 0);
        set_ptr(0, 32'h6040);
        d0 = dcnt0;
        io_write(4'h0, 8'h09);
        push_bytes(0, 10, 2, 0);
        io_write(4'h0, 8'h08);
        io_read(4'h2, v); chk(v == 8'h00, "R9", "status after stop", v, 0);
        @(negedge clk);
        refuse_check(0, 6, "R9");
        chk(dcnt0 == d0, "R9", "no done pulse on stop", dcnt0 - d0, 0);
        chk(wq.size() == 0 && !mem.exists(32'h710A), "R9", "writes ceased", wq.size(), 0);

        // R3 zero count means 65536
        put_desc(32'h6080, 32'h0001_0000, 16'h0000, 1);
        expect_buf(32'h0001_0000, 65536, 3, 0);
        set_ptr(0, 32'h6080);
        d0 = dcnt0;
        io_write(4'h0, 8'h09);
        push_bytes(0, 65536, 3, 0);
        @(negedge clk);
        chk(dcnt0 == d0 + 1, "R3", "done after 65536 bytes", dcnt0 - d0, 1);
        chk(wq.size() == 0, "R3", "all 65536 writes seen", wq.size(), 0);
        io_read(4'h4, v); chk(v == 8'h88, "R4", "ptr advanced by 8", v, 8'h88);
        @(negedge clk);
        refuse_check(0, 3, "R3");

        summary();
    end
endmodule